// File: doc/BRIEF.md
# Backlog-Weighted Diagonal Wave Arbiter

This block is the input-side scheduler of one chip in a multi-chip buffered switch. Once per time slot it pairs K input ports with N output ports. Each input keeps one virtual output queue per output. For every queue the block receives a request flag, which is ON while the queue holds at least one cell, and an 8-bit saturating backlog count. For every output it receives a flag that says the internal buffer of that output is full. It returns a conflict-free grant matrix. Each input gets at most one grant and each output at most one. No grant goes to an output whose buffer is full.

The request cells are grouped into wrapped diagonal waves. With zero-based indices, cell (i, j) belongs to wave (i + j) mod W, where W = max(K, N). No two cells of the same wave share a row or a column. The waves are swept in order, starting from a leading wave and wrapping around. A cell wins only if it requests, its output is not full, and no earlier wave has taken its row or its column. This always yields a maximal matching.

In backlog mode the leading wave is the wave whose summed backlog is largest. The sums use the backlog values latched in the previous slot, and on a tie the lowest index wins. In round-robin mode the leading wave steps forward by one each slot, which gives a reference for comparison.

Top module: `wave_sched`

## Requirements
- R1: While reset is asserted, and until the first slot decision after reset is released, grantOut is all zero, grantValid is 0 and leadWave is 0.
- R2: In every slot, each input row (grant bits i*N to i*N+N-1) holds at most one set bit. Each output column j (bits i*N+j over all i) also holds at most one set bit.
- R3: A grant bit i*N+j is set only if request bit i*N+j was ON and fullIn[j] was 0 for that slot. A full output receives no grant at all.
- R4: The matching is maximal. After a decision, no request with its output not full remains ungranted while both its row and its column are ungranted.
- R5: Waves are visited in the order lead, lead+1, … mod W. Cell (i, j) is in wave (i+j) mod W. A cell is granted exactly when it requests, its output is not full, and neither its row nor its column was granted by an earlier wave.
- R6: With rrMode=0, the leading wave is the index w that maximises the sum of backlogIn fields (i*N+j)*BW to (i*N+j)*BW+BW-1 over all cells with (i+j) mod W = w. The chosen index is reported on leadWave.
- R7: When several waves share the largest weight, the one with the lowest index leads.
- R8: With rrMode=1 in consecutive slots, leadWave increases by one each slot and wraps from W-1 to 0.
- R9: grantValid is 1 exactly when the grant matrix of the same slot has at least one bit set.
- R10: The backlog that picks the leading wave is the one presented one slot earlier. A change of backlogIn shows on leadWave only after a further slot.
- R11: Wave sums do not overflow. A wave of K cells each at 200 outweighs a wave holding a single cell at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one decision per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rrMode | input | 1 | 1 selects the rotating leading wave, 0 selects the heaviest wave |
| reqIn | input | K*N | Request flag per queue, bit i*N+j for input i, output j |
| backlogIn | input | K*N*BW | Backlog count per queue, field (i*N+j)*BW |
| fullIn | input | N | Bit j set means output j's internal buffer is full |
| grantOut | output | K*N | Registered grant matrix, same bit layout as reqIn |
| grantValid | output | 1 | At least one grant is set in grantOut |
| leadWave | output | clog2(max(K,N)) | Leading wave index used for the current grantOut |

## Verification
A corrupted latched backlog or a wrong wave sum shows up as a wrong leadWave index. The grant matrix then differs from the model in the cells where waves compete, one slot after the backlog is applied. A fault in the sweep chaining shows in the same slot as a doubled row or column, a grant to a full output, or a request left unserved while its row and column are both idle. A round-robin pointer that skips or sticks breaks the +1 step of leadWave within one slot. A narrowed adder is caught by the directed sum case.

// File: rtl/wave_sched_pkg.sv
package wave_sched_pkg;

  // Widest leading-wave index the control struct can carry (supports up to 256 waves).
  localparam int LEAD_MAX_W = 8;

  // Strobes handed from the control half to the datapath half each slot.
  typedef struct packed {
    logic                  slotTick;  // datapath may register a new decision
    logic [LEAD_MAX_W-1:0] leadIdx;   // wave that is swept first
  } sched_ctl_t;

  function automatic int waveCount(input int k, input int n);
    return (k > n) ? k : n;
  endfunction

  function automatic int leadBits(input int k, input int n);
    int w;
    w = (k > n) ? k : n;
    return (w > 1) ? $clog2(w) : 1;
  endfunction

endpackage

// File: rtl/wave_sched_ctl.sv
module wave_sched_ctl
  import wave_sched_pkg::*;
#(
  parameter int K  = 4,
  parameter int N  = 12,
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rrMode,
  input  logic [K*N*BW-1:0] backlogIn,
  output sched_ctl_t        ctl
);

  localparam int W     = waveCount(K, N);
  localparam int MINKN = (K < N) ? K : N;
  localparam int SUMW  = BW + $clog2(MINKN + 1);
  localparam int LW    = leadBits(K, N);

  logic [K*N*BW-1:0] backlogQ;
  logic [LW-1:0]     rrPtr;
  logic              runQ;
  logic [W*SUMW-1:0] waveSums;
  logic [LW-1:0]     heavyIdx;

  // Backlog is latched every slot; the decision of the next slot uses it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      backlogQ <= '0;
      rrPtr    <= '0;
      runQ     <= 1'b0;
    end else begin
      backlogQ <= backlogIn;
      runQ     <= 1'b1;
      if (runQ) begin
        rrPtr <= (rrPtr == LW'(W - 1)) ? '0 : rrPtr + 1'b1;
      end
    end
  end

  // One adder tree per wave over the cells lying on that wrapped diagonal.
  for (genvar gw = 0; gw < W; gw++) begin : g_weight
    logic [SUMW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < K; i++) begin
        for (int j = 0; j < N; j++) begin
          if (((i + j) % W) == gw) begin
            acc = acc + SUMW'(backlogQ[(i*N+j)*BW +: BW]);
          end
        end
      end
    end
    assign waveSums[gw*SUMW +: SUMW] = acc;
  end

  // Heaviest wave; strict comparison keeps the lowest index on ties.
  always_comb begin
    logic [SUMW-1:0] best;
    heavyIdx = '0;
    best     = waveSums[0 +: SUMW];
    for (int w = 1; w < W; w++) begin
      if (waveSums[w*SUMW +: SUMW] > best) begin
        best     = waveSums[w*SUMW +: SUMW];
        heavyIdx = LW'(w);
      end
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.slotTick = runQ;
    ctl.leadIdx  = LEAD_MAX_W'(rrMode ? rrPtr : heavyIdx);
  end

endmodule

// File: rtl/wave_sched_dp.sv
module wave_sched_dp
  import wave_sched_pkg::*;
#(
  parameter int K = 4,
  parameter int N = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sched_ctl_t                ctl,
  input  logic [K*N-1:0]            reqIn,
  input  logic [N-1:0]              fullIn,
  output logic [K*N-1:0]            grantOut,
  output logic                      grantValid,
  output logic [leadBits(K,N)-1:0]  leadWave
);

  localparam int W  = waveCount(K, N);
  localparam int LW = leadBits(K, N);

  logic [K*N-1:0] pick;

  // Wave sweep: row-free and column-free flags ripple from wave to wave,
  // so each cell only sees its own request and the two flags handed on.
  always_comb begin
    logic [K-1:0] rowFree;
    logic [N-1:0] colFree;
    int           lead;
    int           wv;
    rowFree = '1;
    colFree = '1;
    pick    = '0;
    lead    = int'(ctl.leadIdx);
    wv      = 0;
    for (int s = 0; s < W; s++) begin
      wv = (lead + s) % W;
      for (int i = 0; i < K; i++) begin
        for (int j = 0; j < N; j++) begin
          if ((((i + j) % W) == wv) && reqIn[i*N+j] && !fullIn[j] &&
              rowFree[i] && colFree[j]) begin
            pick[i*N+j] = 1'b1;
            rowFree[i]  = 1'b0;
            colFree[j]  = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantOut   <= '0;
      grantValid <= 1'b0;
      leadWave   <= '0;
    end else if (ctl.slotTick) begin
      grantOut   <= pick;
      grantValid <= |pick;
      leadWave   <= ctl.leadIdx[LW-1:0];
    end
  end

endmodule

// File: rtl/wave_sched.sv
module wave_sched
  import wave_sched_pkg::*;
#(
  parameter int K  = 4,
  parameter int N  = 12,
  parameter int BW = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rrMode,
  input  logic [K*N-1:0]           reqIn,
  input  logic [K*N*BW-1:0]        backlogIn,
  input  logic [N-1:0]             fullIn,
  output logic [K*N-1:0]           grantOut,
  output logic                     grantValid,
  output logic [leadBits(K,N)-1:0] leadWave
);

  sched_ctl_t ctl;

  wave_sched_ctl #(.K(K), .N(N), .BW(BW)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .rrMode    (rrMode),
    .backlogIn (backlogIn),
    .ctl       (ctl)
  );

  wave_sched_dp #(.K(K), .N(N)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqIn      (reqIn),
    .fullIn     (fullIn),
    .grantOut   (grantOut),
    .grantValid (grantValid),
    .leadWave   (leadWave)
  );

endmodule

// File: rtl/wave_sched_chk.sv
module wave_sched_chk
  import wave_sched_pkg::*;
#(
  parameter int K = 4,
  parameter int N = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     rrMode,
  input logic [K*N-1:0]           reqIn,
  input logic [N-1:0]             fullIn,
  input logic [K*N-1:0]           grantOut,
  input logic                     grantValid,
  input logic [leadBits(K,N)-1:0] leadWave
);

  localparam int W  = waveCount(K, N);
  localparam int LW = leadBits(K, N);

  logic [1:0]     warm;
  logic [K*N-1:0] maskedReq;
  logic [K*N-1:0] reqSeen;
  logic [K-1:0]   rowHas;
  logic [N-1:0]   colHas;
  logic [K*N-1:0] leftover;

  always_comb begin
    for (int i = 0; i < K; i++)
      for (int j = 0; j < N; j++)
        maskedReq[i*N+j] = reqIn[i*N+j] & ~fullIn[j];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warm    <= '0;
      reqSeen <= '0;
    end else begin
      if (warm != 2'd3) warm <= warm + 2'd1;
      reqSeen <= maskedReq;
    end
  end

  always_comb begin
    rowHas = '0;
    colHas = '0;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < N; j++) begin
        rowHas[i] = rowHas[i] | grantOut[i*N+j];
        colHas[j] = colHas[j] | grantOut[i*N+j];
      end
    for (int i = 0; i < K; i++)
      for (int j = 0; j < N; j++)
        leftover[i*N+j] = reqSeen[i*N+j] & ~grantOut[i*N+j] & ~rowHas[i] & ~colHas[j];
  end

  for (genvar gi = 0; gi < K; gi++) begin : g_row
    p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantOut[gi*N +: N]));
  end

  for (genvar gj = 0; gj < N; gj++) begin : g_col
    logic [K-1:0] colBits;
    always_comb begin
      for (int i = 0; i < K; i++) colBits[i] = grantOut[i*N+gj];
    end
    p_col_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(colBits));
  end

  p_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((grantOut & ~reqSeen) == '0));

  p_maximal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2) |-> (leftover == '0));

  p_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (grantOut != '0));

  p_lead_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    int'(leadWave) < W);

  p_rr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rrMode && $past(rrMode) && warm == 2'd3) |=>
      (leadWave == (($past(leadWave) == LW'(W - 1)) ? '0 : $past(leadWave) + 1'b1)));

endmodule

bind wave_sched wave_sched_chk #(.K(K), .N(N)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rrMode     (rrMode),
  .reqIn      (reqIn),
  .fullIn     (fullIn),
  .grantOut   (grantOut),
  .grantValid (grantValid),
  .leadWave   (leadWave)
);

// File: tb/wave_sched_tb.sv
module wave_sched_tb;
  import wave_sched_pkg::*;

  localparam int K          = 4;
  localparam int N          = 12;
  localparam int BW         = 8;
  localparam int W          = (K > N) ? K : N;
  localparam int LW         = leadBits(K, N);
  localparam int CLK_PERIOD = 10;

  logic              clk    = 1'b0;
  logic              rstN   = 1'b0;
  logic              rrMode = 1'b0;
  logic [K*N-1:0]    req    = '0;
  logic [K*N*BW-1:0] bl     = '0;
  logic [N-1:0]      full   = '0;
  logic [K*N-1:0]    grantOut;
  logic              grantValid;
  logic [LW-1:0]     leadWave;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;
  logic [31:0] seed   = 32'h1bad_5eed;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_sched #(.K(K), .N(N), .BW(BW)) u_dut (
    .clk(clk), .rstN(rstN), .rrMode(rrMode), .reqIn(req), .backlogIn(bl),
    .fullIn(full), .grantOut(grantOut), .grantValid(grantValid), .leadWave(leadWave)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic int modelLead(input logic [K*N*BW-1:0] b);
    int sums[W];
    int best;
    for (int w = 0; w < W; w++) sums[w] = 0;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < N; j++)
        sums[(i + j) % W] += int'(b[(i*N+j)*BW +: BW]);
    best = 0;
    for (int w = 1; w < W; w++) if (sums[w] > sums[best]) best = w;
    return best;
  endfunction

  function automatic logic [K*N-1:0] modelGrant(input logic [K*N-1:0] r,
                                                input logic [N-1:0] f, input int lead);
    logic [K*N-1:0] g;
    bit rowUsed[K];
    bit colUsed[N];
    g = '0;
    for (int i = 0; i < K; i++) rowUsed[i] = 1'b0;
    for (int j = 0; j < N; j++) colUsed[j] = 1'b0;
    for (int s = 0; s < W; s++)
      for (int i = 0; i < K; i++)
        for (int j = 0; j < N; j++)
          if ((i + j) % W == (lead + s) % W && r[i*N+j] && !f[j] && !rowUsed[i] && !colUsed[j]) begin
            g[i*N+j] = 1'b1; rowUsed[i] = 1'b1; colUsed[j] = 1'b1;
          end
    return g;
  endfunction

  function automatic int multiCount(input logic [K*N-1:0] g);
    int bad = 0;
    for (int i = 0; i < K; i++) begin
      int c = 0;
      for (int j = 0; j < N; j++) c += int'(g[i*N+j]);
      if (c > 1) bad++;
    end
    for (int j = 0; j < N; j++) begin
      int c = 0;
      for (int i = 0; i < K; i++) c += int'(g[i*N+j]);
      if (c > 1) bad++;
    end
    return bad;
  endfunction

  function automatic int unserved(input logic [K*N-1:0] g, input logic [K*N-1:0] r,
                                  input logic [N-1:0] f);
    int cnt = 0;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < N; j++) begin
        bit rowHit = 1'b0;
        bit colHit = 1'b0;
        for (int x = 0; x < N; x++) rowHit |= g[i*N+x];
        for (int y = 0; y < K; y++) colHit |= g[y*N+j];
        if (r[i*N+j] && !f[j] && !rowHit && !colHit) cnt++;
      end
    return cnt;
  endfunction

  function automatic logic [K*N-1:0] fullCols(input logic [N-1:0] f);
    logic [K*N-1:0] m = '0;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < N; j++) m[i*N+j] = f[j];
    return m;
  endfunction

  task automatic setSlot(input logic [K*N-1:0] r, input logic [K*N*BW-1:0] b,
                         input logic [N-1:0] f);
    @(negedge clk);
    req = r; bl = b; full = f;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkSlot(input string what);
    int lead;
    logic [K*N-1:0] eg;
    lead = modelLead(bl);
    eg   = modelGrant(req, full, lead);
    chk({"R6 lead ", what}, 64'(leadWave), 64'(lead));
    chk({"R5 grant ", what}, 64'(grantOut), 64'(eg));
    chk({"R9 valid ", what}, 64'(grantValid), 64'(eg != '0));
    chk({"R2 conflicts ", what}, 64'(multiCount(grantOut)), 64'd0);
    chk({"R4 unserved ", what}, 64'(unserved(grantOut, req, full)), 64'd0);
    chk({"R3 full cols ", what}, 64'(grantOut & (fullCols(full) | ~req)), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [K*N*BW-1:0] b1;
    logic [K*N*BW-1:0] b2;
    int prevLead;

    // R1: reset state
    #(CLK_PERIOD * 3 + 1);
    chk("R1 grant in reset", 64'(grantOut), 64'd0);
    chk("R1 valid in reset", 64'(grantValid), 64'd0);
    chk("R1 lead in reset", 64'(leadWave), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R7: all-zero backlog ties every wave, lowest index leads
    setSlot('1, '0, '0);
    checkSlot("all ties");
    chk("R7 zero ties", 64'(leadWave), 64'd0);

    // R7: waves 3 and 7 tie at 40
    b1 = '0;
    b1[(0*N+3)*BW +: BW] = 8'd40;
    b1[(0*N+7)*BW +: BW] = 8'd40;
    setSlot('1, b1, '0);
    chk("R7 tie 3 vs 7", 64'(leadWave), 64'd3);
    checkSlot("tie");

    // R11: four cells of 200 on wave 5 beat a single 255 on wave 0
    b1 = '0;
    b1[(0*N+0)*BW +: BW] = 8'd255;
    for (int i = 0; i < K; i++) b1[(i*N + (5 - i))*BW +: BW] = 8'd200;
    setSlot('1, b1, '0);
    chk("R11 wide sum", 64'(leadWave), 64'd5);
    checkSlot("wide sum");

    // R5: all requests on, the leading wave alone fills every row
    b1 = '0;
    for (int i = 0; i < K; i++) b1[(i*N + ((9 + N - i) % N))*BW +: BW] = 8'd7;
    setSlot('1, b1, '0);
    begin
      logic [K*N-1:0] wv = '0;
      for (int i = 0; i < K; i++) wv[i*N + ((9 + N - i) % N)] = 1'b1;
      chk("R5 full wave 9", 64'(grantOut), 64'(wv));
    end

    // R3: alternating full outputs
    setSlot('1, b1, 12'b1010_1010_1010);
    checkSlot("half full");

    // R3: every output full, nothing granted
    setSlot('1, b1, '1);
    chk("R3 all full", 64'(grantOut), 64'd0);
    chk("R9 all full valid", 64'(grantValid), 64'd0);

    // R9: no requests
    setSlot('0, b1, '0);
    chk("R9 idle grant", 64'(grantOut), 64'd0);
    chk("R9 idle valid", 64'(grantValid), 64'd0);

    // R10: the backlog takes effect one slot later
    b1 = '0; b1[(1*N+1)*BW +: BW] = 8'd90;   // wave 2
    b2 = '0; b2[(2*N+8)*BW +: BW] = 8'd90;   // wave 10
    setSlot('1, b1, '0);
    chk("R10 settled", 64'(leadWave), 64'd2);
    @(negedge clk); bl = b2;
    @(posedge clk); @(negedge clk);
    chk("R10 one slot later old", 64'(leadWave), 64'd2);
    @(posedge clk); @(negedge clk);
    chk("R10 two slots later new", 64'(leadWave), 64'd10);

    // R5 R6 R4 R2: sweep of random patterns, several densities and tie-rich backlogs
    for (int t = 0; t < 300; t++) begin
      logic [K*N-1:0]    r;
      logic [K*N*BW-1:0] b;
      logic [N-1:0]      f;
      logic [31:0]       a;
      logic [31:0]       c;
      a = nextRand(); c = nextRand();
      case (t % 3)
        0: r = {a[15:0], c} & {nextRand(), nextRand()};
        1: r = {a[15:0], c};
        default: r = {a[15:0], c} | {nextRand(), nextRand()};
      endcase
      f = (t % 4 == 0) ? N'(nextRand() & nextRand()) : '0;
      for (int x = 0; x < K*N; x++) begin
        logic [31:0] v = nextRand();
        b[x*BW +: BW] = (t % 5 == 0) ? (v[7:0] & 8'h03) : v[7:0];
      end
      setSlot(r, b, f);
      checkSlot("sweep");
    end

    // R8: rotating lead, stepped one slot at a time past the wrap
    @(negedge clk);
    rrMode = 1'b1; req = '1; full = '0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    prevLead = int'(leadWave);
    for (int t = 0; t < 2 * W + 2; t++) begin
      int expL;
      @(posedge clk); @(negedge clk);
      expL = (prevLead + 1) % W;
      chk("R8 rotate step", 64'(leadWave), 64'(expL));
      chk("R8 rotate grant", 64'(grantOut), 64'(modelGrant(req, full, expL)));
      prevLead = int'(leadWave);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule